// File: doc/BRIEF.md
# Byte-Lane Data Memory Access Unit

This unit sits between a 16-bit processor datapath and a byte-addressed data RAM that is 16 bits wide. Each request carries a 16-bit byte address, a byte-or-word size flag, a write flag, write data, and the current high byte of the destination register. Storage is built as two byte-wide lanes. The lanes share one word index and each has its own write enable. A byte access uses address bit 0 to choose a lane. A word access uses both lanes.

The bottom of the map is a register window from 0x0000 to 0x0FFF. In this window, every location reads as zero except one constant register. Addresses at or above 0xE000 are not implemented: they read as zero and writes there are dropped. A word access at an odd address is misaligned. It raises a one-cycle trap pulse. A misaligned read still returns the containing word, and a misaligned write is suppressed. A separate combinational output gives the post-incremented address. It steps by 1 for a byte access and by 2 for a word access.

Requests use a valid/ready handshake, and read results come back on a valid/ready response channel one cycle after acceptance. The unit accepts a request only when the response register is empty or is being drained in the same cycle (`req_ready = !rsp_valid || rsp_ready`). A response that is not taken stays unchanged until `rsp_ready` is high. Writes produce no response.

Top module: `dlu_access_unit`

## Requirements
- R1: An accepted read sets `rsp_valid` in the following cycle. An aligned word read returns the stored word with the even-address byte in bits 7:0 and the odd-address byte in bits 15:8.
- R2: A byte read places the byte chosen by address bit 0 (0 = low lane, 1 = high lane) on `rsp_data[7:0]`, and `req_keep` (captured at acceptance) on `rsp_data[15:8]`.
- R3: A byte write changes only the lane chosen by address bit 0, using `req_wdata[7:0]`. The other byte of the word is unchanged.
- R4: A word access (`req_byte`=0) with address bit 0 set pulses `addr_trap` high for exactly the one cycle after its acceptance. Every other access leaves `addr_trap` low.
- R5: A misaligned word write modifies no storage. A misaligned word read returns the word at the address with bit 0 cleared.
- R6: Reads at addresses 0xE000 and above return zero in every returned bit except the `req_keep` byte of a byte read. Writes there do not reach storage. Storage below the limit is indexed by (address >> 1) modulo 1024 words, so 0xE010 shares an index with 0x2010.
- R7: Reads in 0x0000–0x0FFF return zero, except that the word at 0x0FF0 reads 0xA5C3. Writes in the window do not reach storage, whose index for 0x0FF0 is shared with 0x1FF0.
- R8: `addr_next` equals `req_addr` plus 1 (byte) or 2 (word), modulo 2^16, when `req_post_inc` is 1. It equals `req_addr` when `req_post_inc` is 0.
- R9: While `rsp_valid` is high and `rsp_ready` is low, `req_ready` is low and `rsp_data` holds. An accepted write leaves `rsp_valid` low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high together with valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_byte | input | 1 | 1 = byte access, 0 = word access |
| req_post_inc | input | 1 | Selects stepped address on addr_next |
| req_addr | input | 16 | Byte address |
| req_wdata | input | 16 | Write data (byte writes use bits 7:0) |
| req_keep | input | 8 | Destination high byte kept on byte reads |
| addr_next | output | 16 | Post-increment address |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Read response taken |
| rsp_data | output | 16 | Read response data |
| addr_trap | output | 1 | Misaligned word access pulse |

## Verification
The hardest case to reach is a misaligned word write. Its only visible effect is that nothing changes, so the stimulus first fills the containing word with a known value, issues the odd-address write with different data, and then reads the word back at both the even and odd addresses. The dropped writes in the register window and above the limit are caught the same way: each is aimed at an index shared with a RAM address that was written beforehand, and that RAM address is read back afterwards. Back-pressure is reached by holding `rsp_ready` low while a second request waits, and then releasing it.

// File: rtl/dlu_pkg.sv
package dlu_pkg;
  localparam int BW = 8;
  localparam int NL = 2;
  localparam int DW = BW * NL;

  typedef enum logic [1:0] {
    SRC_RAM   = 2'd0,
    SRC_CONST = 2'd1,
    SRC_ZERO  = 2'd2
  } dlu_src_e;
endpackage

// File: rtl/dlu_addr_decode.sv
module dlu_addr_decode
  import dlu_pkg::*;
#(
  parameter int AW = 16,
  parameter int MEM_WORDS = 1024,
  parameter logic [AW-1:0] WIN_END = 16'h1000,
  parameter logic [AW-1:0] LIMIT = 16'hE000,
  parameter logic [AW-1:0] CONST_ADDR = 16'h0FF0,
  localparam int IW = $clog2(MEM_WORDS)
) (
  input  logic [AW-1:0] addr,
  input  logic          byte_op,
  output dlu_src_e      src,
  output logic          misalign,
  output logic [IW-1:0] idx
);
  logic const_hit;

  assign misalign  = !byte_op && addr[0];
  assign const_hit = (addr[AW-1:1] == CONST_ADDR[AW-1:1]);
  assign idx       = IW'(addr[AW-1:1] % (AW-1)'(MEM_WORDS));

  always_comb begin
    if (addr >= LIMIT)        src = SRC_ZERO;
    else if (addr < WIN_END)  src = const_hit ? SRC_CONST : SRC_ZERO;
    else                      src = SRC_RAM;
  end
endmodule

// File: rtl/dlu_lane_ram.sv
module dlu_lane_ram #(
  parameter int DEPTH = 1024,
  parameter int BW = 8,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [IW-1:0] idx,
  input  logic [BW-1:0] wd,
  output logic [BW-1:0] rd
);
  logic [BW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wd;
    if (re) rd <= mem[idx];
  end
endmodule

// File: rtl/dlu_addr_step.sv
module dlu_addr_step #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] addr,
  input  logic          byte_op,
  input  logic          post_inc,
  output logic [AW-1:0] addr_next
);
  logic [AW-1:0] step;

  assign step      = byte_op ? AW'(1) : AW'(2);
  assign addr_next = post_inc ? addr + step : addr;
endmodule

// File: rtl/dlu_access_unit.sv
module dlu_access_unit
  import dlu_pkg::*;
#(
  parameter int AW = 16,
  parameter int MEM_WORDS = 1024,
  parameter logic [AW-1:0] WIN_END = 16'h1000,
  parameter logic [AW-1:0] LIMIT = 16'hE000,
  parameter logic [AW-1:0] CONST_ADDR = 16'h0FF0,
  parameter logic [DW-1:0] CONST_VALUE = 16'hA5C3,
  localparam int IW = $clog2(MEM_WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic          req_byte,
  input  logic          req_post_inc,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [BW-1:0] req_keep,
  output logic [AW-1:0] addr_next,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [DW-1:0] rsp_data,
  output logic          addr_trap
);
  logic          acc;
  logic          rd_acc;
  dlu_src_e      src;
  logic          misalign;
  logic [IW-1:0] idx;
  logic [NL-1:0] lane_we;
  logic [BW-1:0] lane_wd [NL];
  logic [BW-1:0] lane_rd [NL];

  dlu_src_e      src_q;
  logic          byte_q;
  logic          hisel_q;
  logic [BW-1:0] keep_q;
  logic [DW-1:0] word_w;

  assign req_ready = !rsp_valid || rsp_ready;
  assign acc       = req_valid && req_ready;
  assign rd_acc    = acc && !req_write;

  dlu_addr_decode #(
    .AW(AW), .MEM_WORDS(MEM_WORDS), .WIN_END(WIN_END),
    .LIMIT(LIMIT), .CONST_ADDR(CONST_ADDR)
  ) u_dec (
    .addr(req_addr), .byte_op(req_byte),
    .src(src), .misalign(misalign), .idx(idx)
  );

  dlu_addr_step #(.AW(AW)) u_step (
    .addr(req_addr), .byte_op(req_byte),
    .post_inc(req_post_inc), .addr_next(addr_next)
  );

  for (genvar g = 0; g < NL; g++) begin : g_lane
    assign lane_we[g] = acc && req_write && (src == SRC_RAM) && !misalign
                        && (!req_byte || (req_addr[0] == 1'(g)));
    assign lane_wd[g] = req_byte ? req_wdata[BW-1:0] : req_wdata[g*BW +: BW];

    dlu_lane_ram #(.DEPTH(MEM_WORDS), .BW(BW)) u_ram (
      .clk(clk), .we(lane_we[g]), .re(rd_acc && (src == SRC_RAM)),
      .idx(idx), .wd(lane_wd[g]), .rd(lane_rd[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      addr_trap <= 1'b0;
    end else begin
      addr_trap <= acc && misalign;
      if (acc)            rsp_valid <= !req_write;
      else if (rsp_ready) rsp_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rd_acc) begin
      src_q   <= src;
      byte_q  <= req_byte;
      hisel_q <= req_addr[0];
      keep_q  <= req_keep;
    end
  end

  always_comb begin
    word_w = '0;
    if (src_q == SRC_CONST) word_w = CONST_VALUE;
    else if (src_q == SRC_RAM) begin
      for (int l = 0; l < NL; l++) word_w[l*BW +: BW] = lane_rd[l];
    end
  end

  assign rsp_data = byte_q ? {keep_q, (hisel_q ? word_w[DW-1:BW] : word_w[BW-1:0])}
                           : word_w;
endmodule

// File: rtl/dlu_access_checker.sv
module dlu_access_checker #(
  parameter logic [15:0] LIMIT = 16'hE000
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        req_write,
  input logic        req_byte,
  input logic [15:0] req_addr,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [15:0] rsp_data,
  input logic        addr_trap
);
  logic acc;
  assign acc = req_valid && req_ready;

  p_read_lat_r1: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !req_write |=> rsp_valid);

  p_trap_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !req_byte && req_addr[0] |=> addr_trap);

  p_trap_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc && !req_byte && req_addr[0]) |=> !addr_trap);

  p_zero_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !req_write && !req_byte && (req_addr >= LIMIT) |=> rsp_data == 16'h0000);

  p_rsp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));

  p_write_norsp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_write |=> !rsp_valid);
endmodule

bind dlu_access_unit dlu_access_checker #(.LIMIT(LIMIT)) i_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_byte(req_byte), .req_addr(req_addr),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
  .addr_trap(addr_trap)
);

// File: tb/test_dlu_access_unit.sv
`timescale 1ns/1ps
module test_dlu_access_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic        req_byte = 1'b0;
  logic        req_post_inc = 1'b0;
  logic [15:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [7:0]  req_keep = '0;
  logic [15:0] addr_next;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [15:0] rsp_data;
  logic        addr_trap;

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  dlu_access_unit i_dlu_access_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_byte(req_byte), .req_post_inc(req_post_inc),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_keep(req_keep),
    .addr_next(addr_next), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .addr_trap(addr_trap)
  );

  typedef struct packed {
    logic        wr;
    logic        byt;
    logic [15:0] addr;
    logic [15:0] wdata;
    logic [7:0]  keep;
    logic [15:0] exp;
    logic        trap;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 16'h2000, 16'h1234, 8'h00, 16'h0000, 1'b0, 4'd1}, // R1
    '{1'b0, 1'b0, 16'h2000, 16'h0000, 8'h00, 16'h1234, 1'b0, 4'd1}, // R1
    '{1'b1, 1'b1, 16'h2001, 16'h00AB, 8'h00, 16'h0000, 1'b0, 4'd3}, // R3
    '{1'b0, 1'b0, 16'h2000, 16'h0000, 8'h00, 16'hAB34, 1'b0, 4'd3}, // R3
    '{1'b1, 1'b1, 16'h2000, 16'h00CD, 8'h00, 16'h0000, 1'b0, 4'd3}, // R3
    '{1'b0, 1'b0, 16'h2000, 16'h0000, 8'h00, 16'hABCD, 1'b0, 4'd3}, // R3
    '{1'b0, 1'b1, 16'h2001, 16'h0000, 8'h55, 16'h55AB, 1'b0, 4'd2}, // R2
    '{1'b0, 1'b1, 16'h2000, 16'h0000, 8'h77, 16'h77CD, 1'b0, 4'd2}, // R2
    '{1'b1, 1'b0, 16'h2002, 16'h0F0F, 8'h00, 16'h0000, 1'b0, 4'd5}, // R5
    '{1'b1, 1'b0, 16'h2003, 16'hFFFF, 8'h00, 16'h0000, 1'b1, 4'd4}, // R4
    '{1'b0, 1'b0, 16'h2002, 16'h0000, 8'h00, 16'h0F0F, 1'b0, 4'd5}, // R5
    '{1'b0, 1'b0, 16'h2003, 16'h0000, 8'h00, 16'h0F0F, 1'b1, 4'd5}, // R5
    '{1'b1, 1'b0, 16'h2010, 16'h1111, 8'h00, 16'h0000, 1'b0, 4'd6}, // R6
    '{1'b1, 1'b0, 16'hE010, 16'hDEAD, 8'h00, 16'h0000, 1'b0, 4'd6}, // R6
    '{1'b0, 1'b0, 16'hE010, 16'h0000, 8'h00, 16'h0000, 1'b0, 4'd6}, // R6
    '{1'b0, 1'b1, 16'hFFFF, 16'h0000, 8'h99, 16'h9900, 1'b0, 4'd6}, // R6
    '{1'b0, 1'b0, 16'h2010, 16'h0000, 8'h00, 16'h1111, 1'b0, 4'd6}, // R6
    '{1'b1, 1'b0, 16'h1FF0, 16'h2222, 8'h00, 16'h0000, 1'b0, 4'd7}, // R7
    '{1'b1, 1'b0, 16'h0FF0, 16'h4444, 8'h00, 16'h0000, 1'b0, 4'd7}, // R7
    '{1'b0, 1'b0, 16'h0FF0, 16'h0000, 8'h00, 16'hA5C3, 1'b0, 4'd7}, // R7
    '{1'b0, 1'b1, 16'h0FF1, 16'h0000, 8'h00, 16'h00A5, 1'b0, 4'd7}, // R7
    '{1'b0, 1'b0, 16'h0100, 16'h0000, 8'h00, 16'h0000, 1'b0, 4'd7}, // R7
    '{1'b0, 1'b0, 16'h1FF0, 16'h0000, 8'h00, 16'h2222, 1'b0, 4'd7}, // R7
    '{1'b0, 1'b0, 16'h0FF1, 16'h0000, 8'h00, 16'hA5C3, 1'b1, 4'd4}  // R4
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step_chk(input logic [15:0] a, input logic b, input logic pi,
                          input logic [15:0] exp);
    @(negedge clk);
    req_addr = a; req_byte = b; req_post_inc = pi;
    #1;
    chk("R8 addr_next", addr_next, exp);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<=100000", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 reset rsp_valid", {15'd0, rsp_valid}, 16'd0);
    chk("R4 reset addr_trap", {15'd0, addr_trap}, 16'd0);
    chk("R9 reset req_ready", {15'd0, req_ready}, 16'd1);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      req_valid = 1'b1;
      req_write = VECS[i].wr;
      req_byte  = VECS[i].byt;
      req_addr  = VECS[i].addr;
      req_wdata = VECS[i].wdata;
      req_keep  = VECS[i].keep;
      @(negedge clk);
      req_valid = 1'b0;
      chk($sformatf("R%0d trap v%0d", VECS[i].req, i), {15'd0, addr_trap}, {15'd0, VECS[i].trap});
      if (VECS[i].wr) begin
        chk($sformatf("R9 write no response v%0d", i), {15'd0, rsp_valid}, 16'd0);
      end else begin
        chk($sformatf("R1 rsp_valid v%0d", i), {15'd0, rsp_valid}, 16'd1);
        chk($sformatf("R%0d data v%0d", VECS[i].req, i), rsp_data, VECS[i].exp);
      end
      @(negedge clk);
      chk($sformatf("R4 trap pulse ends v%0d", i), {15'd0, addr_trap}, 16'd0);
    end

    // R8: stepping by size, with wrap and with stepping disabled
    step_chk(16'h00FF, 1'b1, 1'b1, 16'h0100);
    step_chk(16'h1234, 1'b0, 1'b1, 16'h1236);
    step_chk(16'hFFFE, 1'b0, 1'b1, 16'h0000);
    step_chk(16'hFFFF, 1'b1, 1'b1, 16'h0000);
    step_chk(16'h4321, 1'b0, 1'b0, 16'h4321);
    req_post_inc = 1'b0;

    // R9: response held under back-pressure while a second read waits
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_byte = 1'b0; req_addr = 16'h2000;
    @(negedge clk);
    chk("R9 rsp_valid stalled", {15'd0, rsp_valid}, 16'd1);
    chk("R9 data first", rsp_data, 16'hABCD);
    chk("R9 req_ready low", {15'd0, req_ready}, 16'd0);
    req_addr = 16'h2002;
    @(negedge clk);
    chk("R9 data held", rsp_data, 16'hABCD);
    chk("R9 valid held", {15'd0, rsp_valid}, 16'd1);
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9 second data", rsp_data, 16'h0F0F);
    chk("R9 second valid", {15'd0, rsp_valid}, 16'd1);
    @(negedge clk);
    chk("R9 drained", {15'd0, rsp_valid}, 16'd0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule